// File: doc/BRIEF.md
# Dual-Clock Retransmit FIFO

This block carries 36-bit words from a writer clocked by `clk_a` to a reader clocked by `clk_b`. The two clocks run freely and may be unrelated or identical. Every transfer happens on a rising edge of the owning port's clock and only when that port's enable is high. The writer sees full, input-ready and almost-full, all valid in the `clk_a` domain. The reader sees output-ready and almost-empty, both valid in the `clk_b` domain. The output is first-word-fall-through: when output-ready is high, `b_q` already holds the head word.

Two threshold offsets set the almost-flags. Offset X applies to free space and offset Y applies to stored words. Both reset to 8. The writer can reload them in one cycle from its data bus, or shift them in one bit per cycle on a serial pin. The reader can mark a point in the stream and later jump back to it, then read the words from there again. While the mark is held, storage behind the mark stays protected, so the writer's free space is counted from the mark and not from the read position.

Top module: `xclk_fifo_rt`

## Requirements
- R1: Words come out on port B in the order they were written on port A, with no loss or duplication, across any number of pointer wraps. Pointers cross between domains in Gray code, so a synchronized pointer changes by at most one bit per source clock.
- R2: `b_or` high means `b_q` holds the head word. A read is taken on a rising `clk_b` when `b_ren` and `b_or` are both high. Without a read, `b_q` and `b_or` hold their values.
- R3: `a_full` is high when 2^AW words are held. `a_ir` is low while full. A write attempted with `a_ir` low stores nothing.
- R4: `b_ren` while `b_or` is low has no effect. The head is not consumed, and the first word written afterwards is still delivered first.
- R5: `a_afull` is high exactly when free space ≤ X, and X is 8 after reset.
- R6: `b_ae` is high exactly when the stored count (including the word on `b_q`) ≤ Y, and Y is 8 after reset.
- R7: `a_ofs_ld` high for one `clk_a` cycle loads X from `a_data[OFFW-1:0]` and Y from `a_data[2*OFFW-1:OFFW]`. A write requested in that same cycle is ignored.
- R8: Each `clk_a` cycle with `a_ser_en` high shifts in `a_ser_d`. The sequence is 2*OFFW bits: Y first, then X, each MSB first. The new values take effect after the last bit. `a_ir` is low from the first bit until the load completes, and writes during the load are ignored.
- R9: A rise of `b_mark` records the head word. `b_rtx`, while the mark has been held since the previous cycle, drops `b_or` for that cycle. The next word delivered is then the marked word, followed by its successors in order.
- R10: While a mark is held, free space is measured from the mark. After 2^AW words past the mark, the writer stays full even if they have all been read. Releasing the mark frees the space.
- R11: `b_rtx` with no held mark is ignored.
- R12: After reset: `a_ir`=1, `a_full`=0, `a_afull`=0, `b_or`=0, `b_ae`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| rst_a_n | input | 1 | Write-side reset, active low, asynchronous assert |
| a_data | input | DW | Write data / parallel offset word |
| a_wen | input | 1 | Write enable |
| a_ofs_ld | input | 1 | Parallel offset load strobe |
| a_ser_en | input | 1 | Serial offset shift enable |
| a_ser_d | input | 1 | Serial offset data bit |
| a_ir | output | 1 | Input ready |
| a_full | output | 1 | Full flag |
| a_afull | output | 1 | Almost-full flag |
| clk_b | input | 1 | Read-side clock |
| rst_b_n | input | 1 | Read-side reset, active low, asynchronous assert |
| b_ren | input | 1 | Read enable |
| b_mark | input | 1 | Retransmit mark, held high while protected |
| b_rtx | input | 1 | Retransmit request |
| b_q | output | DW | Head word |
| b_or | output | 1 | Output ready |
| b_ae | output | 1 | Almost-empty flag |

## Verification
The bench builds the block with AW=4, a 16-word store, and OFFW=4, while keeping the 36-bit word. With so few entries, a run of 40 streamed words wraps both pointers more than twice. Full, the mark-protected full and both almost-flag thresholds all fall within a handful of writes. Those small offsets also make an 8-bit serial load, with its thresholds placed near both ends of the store, cheap to exercise.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int unsigned WORD_W  = 36;
  localparam int unsigned ADDR_W  = 11;
  localparam int unsigned OFS_W   = 11;
  localparam int unsigned OFS_DEF = 8;
endpackage

// File: rtl/xf_sync.sv
// Two-flop synchronizer with a chosen reset value.
module xf_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST;
      q      <= RST;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/xf_g2b.sv
// Gray to binary: bit i is the parity of all Gray bits at or above i.
module xf_g2b #(
  parameter int W = 4
) (
  input  logic [W-1:0] g,
  output logic [W-1:0] b
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b[i] = ^g[W-1:i];
  end
endmodule

// File: rtl/xf_mem.sv
// Storage array: written in the A domain, read address driven from the B domain.
module xf_mem #(
  parameter int DW = 36,
  parameter int AW = 11
) (
  input  logic          clk_w,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];

  always_ff @(posedge clk_w) begin
    if (we) ram[wa] <= wd;
  end

  assign rd = ram[ra];
endmodule

// File: rtl/xf_wr_ctl.sv
// Write side: pointer, full / ready / almost-full, offset registers.
module xf_wr_ctl #(
  parameter int DW      = 36,
  parameter int AW      = 11,
  parameter int OFFW    = 11,
  parameter int OFS_RST = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wen,
  input  logic [DW-1:0]   data,
  input  logic            ofs_ld,
  input  logic            ser_en,
  input  logic            ser_d,
  input  logic [AW:0]     lim_gray_s,
  output logic            we,
  output logic [AW-1:0]   waddr,
  output logic [AW:0]     wbin,
  output logic [AW:0]     wgray,
  output logic            ir,
  output logic            full,
  output logic            afull,
  output logic [OFFW-1:0] ofs_y
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int SW    = 2 * OFFW;
  localparam int CW    = $clog2(SW + 1);

  logic [PW-1:0]   wbin_q, wbin_d, wgray_q, wgray_d, lim_bin, used, free;
  logic [OFFW-1:0] x_q, x_d, y_q, y_d;
  logic [SW-1:0]   sh_q, sh_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            accept;

  xf_g2b #(.W(PW)) u_lim_g2b (.g(lim_gray_s), .b(lim_bin));

  always_comb begin
    used   = wbin_q - lim_bin;
    free   = PW'(DEPTH) - used;
    full   = (used == PW'(DEPTH));
    afull  = (32'(free) <= 32'(x_q));
    ir     = !full && (cnt_q == '0);
    accept = wen && ir && !ofs_ld && !ser_en;
    wbin_d = wbin_q + PW'(accept);
    wgray_d = wbin_d ^ (wbin_d >> 1);

    x_d   = x_q;
    y_d   = y_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (ofs_ld) begin
      x_d = data[OFFW-1:0];
      y_d = data[SW-1:OFFW];
    end else if (ser_en) begin
      sh_d = {sh_q[SW-2:0], ser_d};
      if (cnt_q == CW'(SW - 1)) begin
        cnt_d = '0;
        y_d   = sh_d[SW-1:OFFW];
        x_d   = sh_d[OFFW-1:0];
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      x_q     <= OFFW'(OFS_RST);
      y_q     <= OFFW'(OFS_RST);
      sh_q    <= '0;
      cnt_q   <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      x_q     <= x_d;
      y_q     <= y_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
    end
  end

  assign we    = accept;
  assign waddr = wbin_q[AW-1:0];
  assign wbin  = wbin_q;
  assign wgray = wgray_q;
  assign ofs_y = y_q;
endmodule

// File: rtl/xf_rd_ctl.sv
// Read side: fetch and head pointers, output register, mark / retransmit,
// and the write-limit pointer exported to the A domain.
module xf_rd_ctl #(
  parameter int DW   = 36,
  parameter int AW   = 11,
  parameter int OFFW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ren,
  input  logic            mark,
  input  logic            rtx,
  input  logic [AW:0]     wgray_s,
  input  logic [OFFW-1:0] ofs_y,
  input  logic [DW-1:0]   rdata,
  output logic [AW-1:0]   raddr,
  output logic [DW-1:0]   q,
  output logic            o_rdy,
  output logic            ae,
  output logic [AW:0]     hptr,
  output logic            hold,
  output logic [AW:0]     lim_gray
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin_s, rptr_q, rptr_d, hptr_q, hptr_d, mark_q, mark_d;
  logic [PW-1:0] lim_q, lim_d, lgray_q, lgray_d, tgt, stored;
  logic [DW-1:0] q_q, q_d;
  logic          or_q, or_d, hold_q, take, have, do_rtx;

  xf_g2b #(.W(PW)) u_w_g2b (.g(wgray_s), .b(wbin_s));

  always_comb begin
    have   = (rptr_q != wbin_s);
    take   = ren && or_q;
    do_rtx = rtx && hold_q;
    rptr_d = rptr_q;
    hptr_d = hptr_q;
    q_d    = q_q;
    or_d   = or_q;
    if (do_rtx) begin
      rptr_d = mark_q;
      hptr_d = mark_q;
      or_d   = 1'b0;
    end else begin
      if (take) hptr_d = hptr_q + PW'(1);
      if ((!or_q || take) && have) begin
        q_d    = rdata;
        rptr_d = rptr_q + PW'(1);
        or_d   = 1'b1;
      end else if (take) begin
        or_d = 1'b0;
      end
    end

    mark_d = (mark && !hold_q) ? hptr_q : mark_q;
    // The exported limit walks one step per clock so its Gray code
    // never changes by more than one bit, even when a mark is released.
    tgt     = hold_q ? mark_q : hptr_q;
    lim_d   = (lim_q != tgt) ? lim_q + PW'(1) : lim_q;
    lgray_d = lim_d ^ (lim_d >> 1);

    stored = wbin_s - hptr_q;
    ae     = (32'(stored) <= 32'(ofs_y));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q  <= '0;
      hptr_q  <= '0;
      mark_q  <= '0;
      hold_q  <= 1'b0;
      lim_q   <= '0;
      lgray_q <= '0;
      q_q     <= '0;
      or_q    <= 1'b0;
    end else begin
      rptr_q  <= rptr_d;
      hptr_q  <= hptr_d;
      mark_q  <= mark_d;
      hold_q  <= mark;
      lim_q   <= lim_d;
      lgray_q <= lgray_d;
      q_q     <= q_d;
      or_q    <= or_d;
    end
  end

  assign raddr    = rptr_q[AW-1:0];
  assign q        = q_q;
  assign o_rdy    = or_q;
  assign hptr     = hptr_q;
  assign hold     = hold_q;
  assign lim_gray = lgray_q;
endmodule

// File: rtl/xclk_fifo_rt.sv
module xclk_fifo_rt #(
  parameter int DW      = xf_pkg::WORD_W,
  parameter int AW      = xf_pkg::ADDR_W,
  parameter int OFFW    = xf_pkg::OFS_W,
  parameter int OFS_RST = xf_pkg::OFS_DEF
) (
  input  logic          clk_a,
  input  logic          rst_a_n,
  input  logic [DW-1:0] a_data,
  input  logic          a_wen,
  input  logic          a_ofs_ld,
  input  logic          a_ser_en,
  input  logic          a_ser_d,
  output logic          a_ir,
  output logic          a_full,
  output logic          a_afull,
  input  logic          clk_b,
  input  logic          rst_b_n,
  input  logic          b_ren,
  input  logic          b_mark,
  input  logic          b_rtx,
  output logic [DW-1:0] b_q,
  output logic          b_or,
  output logic          b_ae
);
  localparam int PW = AW + 1;

  logic            ra_n, rb_n, we;
  logic [AW-1:0]   waddr, raddr;
  logic [DW-1:0]   rdata;
  logic [PW-1:0]   wbin, wgray, wgray_s, lim_gray, lim_gray_s, hptr;
  logic [OFFW-1:0] ofs_y_a, ofs_y_b;
  logic            hold;

  // Reset release is synchronized into each domain.
  xf_sync #(.W(1), .RST(1'b0)) u_rst_a (.clk(clk_a), .rst_n(rst_a_n), .d(1'b1), .q(ra_n));
  xf_sync #(.W(1), .RST(1'b0)) u_rst_b (.clk(clk_b), .rst_n(rst_b_n), .d(1'b1), .q(rb_n));

  xf_sync #(.W(PW)) u_wptr_sync (.clk(clk_b), .rst_n(rb_n), .d(wgray), .q(wgray_s));
  xf_sync #(.W(PW)) u_lim_sync  (.clk(clk_a), .rst_n(ra_n), .d(lim_gray), .q(lim_gray_s));
  // Offset Y is configuration, expected to change only while the reader is idle.
  xf_sync #(.W(OFFW), .RST(OFFW'(OFS_RST))) u_ofs_sync (
    .clk(clk_b), .rst_n(rb_n), .d(ofs_y_a), .q(ofs_y_b));

  xf_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_w(clk_a), .we(we), .wa(waddr), .wd(a_data), .ra(raddr), .rd(rdata));

  xf_wr_ctl #(.DW(DW), .AW(AW), .OFFW(OFFW), .OFS_RST(OFS_RST)) u_wr (
    .clk(clk_a), .rst_n(ra_n), .wen(a_wen), .data(a_data), .ofs_ld(a_ofs_ld),
    .ser_en(a_ser_en), .ser_d(a_ser_d), .lim_gray_s(lim_gray_s), .we(we),
    .waddr(waddr), .wbin(wbin), .wgray(wgray), .ir(a_ir), .full(a_full),
    .afull(a_afull), .ofs_y(ofs_y_a));

  xf_rd_ctl #(.DW(DW), .AW(AW), .OFFW(OFFW)) u_rd (
    .clk(clk_b), .rst_n(rb_n), .ren(b_ren), .mark(b_mark), .rtx(b_rtx),
    .wgray_s(wgray_s), .ofs_y(ofs_y_b), .rdata(rdata), .raddr(raddr), .q(b_q),
    .o_rdy(b_or), .ae(b_ae), .hptr(hptr), .hold(hold), .lim_gray(lim_gray));
endmodule

// File: rtl/xclk_fifo_rt_chk.sv
module xclk_fifo_rt_chk #(
  parameter int DW = 36,
  parameter int PW = 12
) (
  input logic          clk_a,
  input logic          rst_a_n,
  input logic          clk_b,
  input logic          rst_b_n,
  input logic          a_full,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] wgray,
  input logic          b_or,
  input logic          b_ren,
  input logic          b_rtx,
  input logic [DW-1:0] b_q,
  input logic [PW-1:0] hptr,
  input logic          hold,
  input logic [PW-1:0] lim_gray
);
  // R3
  no_overflow_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    a_full |=> (wbin == $past(wbin)));

  // R4
  no_underflow_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (!b_or && !(b_rtx && hold)) |=> $stable(hptr));

  // R2
  head_hold_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    (b_or && !b_ren && !b_rtx) |=> (b_or && $stable(b_q)));

  // R1
  wgray_step_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R1
  lgray_step_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
    $countones(lim_gray ^ $past(lim_gray)) <= 1);
endmodule

bind xclk_fifo_rt xclk_fifo_rt_chk #(.DW(DW), .PW(AW + 1)) u_chk (
  .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
  .a_full(a_full), .wbin(wbin), .wgray(wgray), .b_or(b_or), .b_ren(b_ren),
  .b_rtx(b_rtx), .b_q(b_q), .hptr(hptr), .hold(hold), .lim_gray(lim_gray));

// File: tb/test_xclk_fifo_rt.sv
`timescale 1ns/1ps
module test_xclk_fifo_rt;
  localparam int DW = 36, AW = 4, OFFW = 4;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a_n, rst_b_n;
  logic [DW-1:0] a_data;
  logic a_wen, a_ofs_ld, a_ser_en, a_ser_d, a_ir, a_full, a_afull;
  logic b_ren, b_mark, b_rtx, b_or, b_ae;
  logic [DW-1:0] b_q;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  xclk_fifo_rt #(.DW(DW), .AW(AW), .OFFW(OFFW), .OFS_RST(8)) i_xclk_fifo_rt (.*);

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] hist[$];
  int ridx = 0, mark_idx = 0, cyc = 0, seq = 0;
  bit rd_on = 0, mark_want = 0, rtx_req = 0;
  logic [7:0] rd_pat = 8'hFF;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor / reader model: runs between rising edges of clk_b.
  always @(negedge clk_b) begin
    if (!rst_b_n) begin
      b_ren = 0; b_rtx = 0; b_mark = 0;
    end else begin
      logic old_mark, ren_n;
      old_mark = b_mark;
      if (mark_want && !old_mark) mark_idx = ridx;
      b_mark = mark_want;
      b_rtx = 0;
      if (rtx_req) begin
        rtx_req = 0;
        b_rtx = 1;
        b_ren = 0;
        if (old_mark) ridx = mark_idx;
      end else begin
        ren_n = rd_on && rd_pat[cyc % 8];
        cyc++;
        if (ren_n && b_or) begin
          if (ridx < hist.size()) chk("R1 word order", b_q, hist[ridx]);
          else chk("R1 unexpected extra word", b_q, 64'hDEAD);
          ridx++;
        end
        b_ren = ren_n;
      end
    end
  end

  task automatic settle();
    repeat (40) @(negedge clk_b);
  endtask

  task automatic do_reset();
    rd_on = 0; mark_want = 0; rtx_req = 0;
    a_wen = 0; a_ofs_ld = 0; a_ser_en = 0; a_ser_d = 0; a_data = '0;
    rst_a_n = 0; rst_b_n = 0;
    repeat (3) @(negedge clk_b);
    hist.delete(); ridx = 0;
    rst_a_n = 1; rst_b_n = 1;
    repeat (6) @(negedge clk_b);
  endtask

  task automatic push(input logic [DW-1:0] v);
    @(negedge clk_a);
    while (!a_ir) @(negedge clk_a);
    a_data = v; a_wen = 1; hist.push_back(v);
    @(negedge clk_a);
    a_wen = 0;
  endtask

  task automatic push_n(input int n);
    for (int k = 0; k < n; k++) begin
      seq++;
      push({4'h5, 32'(seq * 32'h9E37_79B1)});
    end
  endtask

  task automatic try_write(input logic [DW-1:0] v);
    @(negedge clk_a);
    a_data = v; a_wen = 1;
    @(negedge clk_a);
    a_wen = 0;
  endtask

  task automatic drain(input string tag);
    rd_on = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk_b);
      if (ridx == hist.size() && !b_or) break;
    end
    rd_on = 0;
    settle();
    chk({tag, " all words delivered"}, ridx, hist.size());
    chk({tag, " output idle after drain"}, b_or, 0);
  endtask

  initial begin
    #500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_a_n = 0; rst_b_n = 0;
    do_reset();
    // R12 reset state
    chk("R12 a_ir", a_ir, 1);
    chk("R12 a_full", a_full, 0);
    chk("R12 a_afull", a_afull, 0);
    chk("R12 b_or", b_or, 0);
    chk("R12 b_ae", b_ae, 1);

    // R5 / R6 default offsets, R3 full and ignored write
    push_n(7); settle();
    chk("R5 free 9 > 8", a_afull, 0);
    chk("R6 count 7 <= 8", b_ae, 1);
    push_n(1); settle();
    chk("R5 free 8 <= 8", a_afull, 1);
    chk("R6 count 8 <= 8", b_ae, 1);
    push_n(1); settle();
    chk("R6 count 9 > 8", b_ae, 0);
    push_n(7); settle();
    chk("R3 full at depth", a_full, 1);
    chk("R3 not ready when full", a_ir, 0);
    try_write(36'hBAD_BAD_BAD);
    drain("R3 ignored write");
    chk("R3 not full after drain", a_full, 0);

    // R4 reads while empty have no effect
    do_reset();
    rd_pat = 8'b0101_1101; rd_on = 1;
    repeat (20) @(negedge clk_b);
    rd_on = 0;
    push_n(3); settle();
    chk("R4 output ready", b_or, 1);
    chk("R4 R2 head word", b_q, hist[0]);
    drain("R4");

    // R1 streaming with both clocks running and wraps
    rd_pat = 8'b1011_0110; rd_on = 1;
    push_n(40);
    drain("R1 stream");
    rd_pat = 8'hFF;

    // R7 parallel offsets X=3, Y=5 with a simultaneous write
    do_reset();
    @(negedge clk_a);
    a_data = 36'h53; a_ofs_ld = 1; a_wen = 1;
    @(negedge clk_a);
    a_ofs_ld = 0; a_wen = 0;
    settle();
    push_n(5); settle();
    chk("R7 count 5 <= Y", b_ae, 1);
    push_n(1); settle();
    chk("R7 count 6 > Y", b_ae, 0);
    chk("R7 free 10 > X", a_afull, 0);
    push_n(6); settle();
    chk("R7 free 4 > X", a_afull, 0);
    push_n(1); settle();
    chk("R7 free 3 <= X", a_afull, 1);
    drain("R7");

    // R8 serial offsets: Y=2 then X=6, MSB first
    do_reset();
    begin
      logic [7:0] bits;
      bits = 8'b0010_0110;
      for (int i = 7; i >= 0; i--) begin
        @(negedge clk_a);
        if (i == 6) chk("R8 not ready during load", a_ir, 0);
        a_ser_en = 1; a_ser_d = bits[i];
        a_wen = (i == 7 || i == 3); a_data = 36'hBAD;
      end
      @(negedge clk_a);
      a_ser_en = 0; a_wen = 0;
      chk("R8 ready after load", a_ir, 1);
    end
    settle();
    push_n(2); settle();
    chk("R8 count 2 <= Y", b_ae, 1);
    push_n(1); settle();
    chk("R8 count 3 > Y", b_ae, 0);
    push_n(6); settle();
    chk("R8 free 7 > X", a_afull, 0);
    push_n(1); settle();
    chk("R8 free 6 <= X", a_afull, 1);
    drain("R8");

    // R9 mark then retransmit
    do_reset();
    mark_want = 1;
    repeat (3) @(negedge clk_b);
    push_n(6);
    drain("R9 first pass");
    rtx_req = 1;
    settle();
    chk("R9 output ready after retransmit", b_or, 1);
    chk("R9 marked word at head", b_q, hist[0]);
    drain("R9 second pass");

    // R10 held mark limits free space
    do_reset();
    mark_want = 1;
    repeat (3) @(negedge clk_b);
    push_n(16);
    drain("R10 read past mark");
    chk("R10 full while mark held", a_full, 1);
    chk("R10 not ready while mark held", a_ir, 0);
    mark_want = 0;
    settle();
    chk("R10 space after release", a_full, 0);
    chk("R10 ready after release", a_ir, 1);

    // R11 retransmit without a held mark
    push_n(2);
    drain("R11 setup");
    rtx_req = 1;
    settle();
    chk("R11 no replay", b_or, 0);
    push_n(1);
    drain("R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule